// File: doc/BRIEF.md
# SPI Read Response Scanner

After a host issues a single-register or internal-register read over SPI, the target returns a burst of bytes. This block consumes that burst one byte at a time and turns it into a 32-bit result and a completion code. The bytes are checked in order. The echoed opcode comes first, then a status byte. A variable-length run of filler bytes follows, then a data-start marker, four data bytes and, optionally, a 16-bit CRC over those data bytes.

A start strobe arms the scanner. On that strobe it captures the expected opcode, a clockless flag and a CRC-enable flag for the access. Clockless accesses can return an unreliable echo and status, so for them the scanner skips those checks and does not check the CRC. The scanner finishes on the first error it finds, or when the last expected byte arrives. It then gives a one-cycle done pulse, the result code, and the assembled data word.

Top module: `rsp_scan`

## Requirements
- R1: After reset `done_o` is 0, `err_o` is 0 and `word_o` is 0. A `start_i` pulse captures `opcode_i`, `clockless_i` and `crc_en_i` and restarts the scan from the echo byte, even in the middle of a response.
- R2: Unless the access is clockless, the first accepted byte must equal the captured opcode. Otherwise, in the cycle after that byte, `done_o` pulses with `err_o` = 1 (echo mismatch).
- R3: Unless the access is clockless, the second accepted byte must be 0x00. Otherwise, in the cycle after that byte, `done_o` pulses with `err_o` = 2 (bad status).
- R4: For a clockless access, any echo and status values are accepted, and no CRC bytes are expected even when `crc_en_i` was 1.
- R5: Up to 8 bytes after the status are scanned. The first byte whose bits 7:4 equal 0xF is the data-start marker. Bytes before it, for example 0x00 fillers, are skipped without error, and a marker in the 8th position is still accepted.
- R6: If none of the 8 bytes after the status is a marker, `done_o` pulses with `err_o` = 3 (missing start) in the cycle after the 8th byte.
- R7: The four bytes after the marker form `word_o`, with the first of them in bits 31:24. When no CRC is expected, `done_o` pulses with `err_o` = 0 in the cycle after the fourth data byte.
- R8: When CRC is enabled and the access is not clockless, two more bytes follow the data, high byte first. They must equal the CRC-16 over the four data bytes: polynomial 0x1021, seed 0xFFFF, MSB first, no final inversion. `err_o` is 0 on a match and 4 (CRC mismatch) otherwise, reported in the cycle after the low CRC byte.
- R9: `done_o` is high for exactly one cycle per response, and `err_o` is 0 whenever `done_o` is low. Cycles with `rx_valid_i` low do not advance the scan.
- R10: Bytes that arrive after completion, or before any start, are ignored: they produce no `done_o` pulse and leave `word_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms a new scan and captures the access settings |
| opcode_i | input | 8 | Expected echo opcode, captured on start |
| clockless_i | input | 1 | Clockless access flag, captured on start |
| crc_en_i | input | 1 | Data CRC enable, captured on start |
| rx_valid_i | input | 1 | Qualifies `rx_byte_i` |
| rx_byte_i | input | 8 | Received response byte |
| word_o | output | 32 | Assembled data word |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code: 0 ok, 1 echo, 2 status, 3 no start, 4 CRC |

## Verification
A wrong stage register shows up as a completion in the wrong cycle. Done arrives early or late by one or more bytes, or never arrives. Because every test drives an exact byte count and checks `done_o` both before and after the final byte, the error is visible within one byte. A stuck or miscounted filler counter moves the missing-start error away from the 8th filler byte, or makes a marker in the 8th position fail. A wrong data shift order or a wrong CRC state corrupts `word_o` or `err_o` on the first good response that uses it.

// File: rtl/rsp_scan_pkg.sv
`timescale 1ns/1ps
package rsp_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ECHO, ST_STAT, ST_HUNT, ST_DATA, ST_CRCH, ST_CRCL
  } scan_st_e;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_CMD     = 3'd1,
    RC_STATUS  = 3'd2,
    RC_NOSTART = 3'd3,
    RC_CRC     = 3'd4
  } rsp_code_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // One byte of an MSB-first CRC-16 update.
  function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
    logic [15:0] c;
    c = cur ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) begin
      c = c[15] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rsp_crc16.sv
`timescale 1ns/1ps
module rsp_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import rsp_scan_pkg::*;

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr_i)     crc_d = SEED;
    else if (en_i) crc_d = crc16_step(crc_q, byte_i, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              crc_q <= SEED;
    else if (clr_i || en_i)  crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R8: clearing re-seeds the accumulator
  p_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == SEED));

endmodule

// File: rtl/rsp_word_asm.sv
`timescale 1ns/1ps
module rsp_word_asm #(
  parameter int NBYTES = 4,
  localparam int WW = 8 * NBYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic [7:0]    byte_i,
  output logic [WW-1:0] word_o
);
  logic [WW-1:0] word_q, word_d;

  generate
    if (NBYTES > 1) begin : g_multi
      always_comb begin
        word_d = word_q;
        if (clr_i)        word_d = '0;
        else if (shift_i) word_d = {word_q[WW-9:0], byte_i};
      end
    end else begin : g_single
      always_comb begin
        word_d = word_q;
        if (clr_i)        word_d = '0;
        else if (shift_i) word_d = byte_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                word_q <= '0;
    else if (clr_i || shift_i) word_q <= word_d;
  end

  assign word_o = word_q;

  // R7: newest byte lands in the low lane
  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i) |=> (word_o[7:0] == $past(byte_i)));

  // R10: without a shift or clear the word holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !clr_i) |=> $stable(word_o));

endmodule

// File: rtl/rsp_scan.sv
`timescale 1ns/1ps
module rsp_scan #(
  parameter int        WIN    = 8,
  parameter int        NBYTES = 4,
  parameter logic [3:0] MARK  = 4'hF,
  localparam int       WW     = 8 * NBYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic          clockless_i,
  input  logic          crc_en_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_byte_i,
  output logic [WW-1:0] word_o,
  output logic          done_o,
  output logic [2:0]    err_o
);
  import rsp_scan_pkg::*;

  localparam int CNT_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

  scan_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]      op_q, op_d;
  logic            cl_q, cl_d;
  logic            chk_q, chk_d;
  logic [7:0]      hi_q, hi_d;
  logic            done_q, done_d;
  rsp_code_e       err_q, err_d;
  logic            crc_clr, crc_upd, w_clr, w_shift;
  logic [15:0]     crc_w;
  logic            is_mark;

  assign is_mark = (rx_byte_i[7:4] == MARK);

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    op_d    = op_q;
    cl_d    = cl_q;
    chk_d   = chk_q;
    hi_d    = hi_q;
    done_d  = 1'b0;
    err_d   = RC_OK;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    w_clr   = 1'b0;
    w_shift = 1'b0;
    if (start_i) begin
      st_d    = ST_ECHO;
      op_d    = opcode_i;
      cl_d    = clockless_i;
      chk_d   = crc_en_i & ~clockless_i;
      cnt_d   = '0;
      idx_d   = '0;
      crc_clr = 1'b1;
      w_clr   = 1'b1;
    end else if (rx_valid_i) begin
      unique case (st_q)
        ST_ECHO: begin
          if (!cl_q && (rx_byte_i != op_q)) begin
            st_d = ST_IDLE; done_d = 1'b1; err_d = RC_CMD;
          end else begin
            st_d = ST_STAT;
          end
        end
        ST_STAT: begin
          if (!cl_q && (rx_byte_i != 8'h00)) begin
            st_d = ST_IDLE; done_d = 1'b1; err_d = RC_STATUS;
          end else begin
            st_d  = ST_HUNT;
            cnt_d = '0;
          end
        end
        ST_HUNT: begin
          if (is_mark) begin
            st_d  = ST_DATA;
            idx_d = '0;
          end else if (cnt_q == CNT_LAST) begin
            st_d = ST_IDLE; done_d = 1'b1; err_d = RC_NOSTART;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          w_shift = 1'b1;
          crc_upd = 1'b1;
          if (idx_q == IDX_LAST) begin
            if (chk_q) begin
              st_d = ST_CRCH;
            end else begin
              st_d = ST_IDLE; done_d = 1'b1; err_d = RC_OK;
            end
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        ST_CRCH: begin
          hi_d = rx_byte_i;
          st_d = ST_CRCL;
        end
        ST_CRCL: begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          err_d  = ({hi_q, rx_byte_i} == crc_w) ? RC_OK : RC_CRC;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      op_q   <= '0;
      cl_q   <= 1'b0;
      chk_q  <= 1'b0;
      hi_q   <= '0;
      done_q <= 1'b0;
      err_q  <= RC_OK;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      op_q   <= op_d;
      cl_q   <= cl_d;
      chk_q  <= chk_d;
      hi_q   <= hi_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  rsp_crc16 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (crc_clr),
    .en_i   (crc_upd),
    .byte_i (rx_byte_i),
    .crc_o  (crc_w)
  );

  rsp_word_asm #(.NBYTES(NBYTES)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (w_clr),
    .shift_i (w_shift),
    .byte_i  (rx_byte_i),
    .word_o  (word_o)
  );

  assign done_o = done_q;
  assign err_o  = err_q;

  // R2: echo mismatch ends the scan with code 1
  p_echo_chk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ECHO && rx_valid_i && !start_i && !cl_q && rx_byte_i != op_q)
      |=> (done_o && err_o == 3'd1));

  // R3: nonzero status ends the scan with code 2
  p_status_chk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STAT && rx_valid_i && !start_i && !cl_q && rx_byte_i != 8'h00)
      |=> (done_o && err_o == 3'd2));

  // R4: clockless echo and status never complete the scan
  p_clockless_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ECHO || st_q == ST_STAT) && rx_valid_i && !start_i && cl_q)
      |=> !done_o);

  // R6: a non-marker at the window limit reports missing start
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT && rx_valid_i && !start_i && !is_mark && cnt_q == CNT_LAST)
      |=> (done_o && err_o == 3'd3));

  // R8: the checked CRC word agrees with the accumulator
  p_crc_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CRCL && rx_valid_i && !start_i && {hi_q, rx_byte_i} != crc_w)
      |=> (done_o && err_o == 3'd4));

  // R9: completion is a single-cycle pulse, code quiet otherwise
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (err_o == 3'd0));

  // R10: an idle scanner never completes
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> !done_o);

endmodule

// File: tb/rsp_scan_tb_top.sv
`timescale 1ns/1ps
module rsp_scan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  opcode_i;
  logic        clockless_i;
  logic        crc_en_i;
  logic        rx_valid_i;
  logic [7:0]  rx_byte_i;
  logic [31:0] word_o;
  logic        done_o;
  logic [2:0]  err_o;

  int nchk  = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  rsp_scan dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .clockless_i(clockless_i), .crc_en_i(crc_en_i), .rx_valid_i(rx_valid_i),
    .rx_byte_i(rx_byte_i), .word_o(word_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [15:0] ref_crc(input logic [31:0] w);
    logic [15:0] c = 16'hFFFF;
    for (int i = 3; i >= 0; i--) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ w[i*8+b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [7:0] op, input logic cl, input logic ce);
    start_i = 1'b1; opcode_i = op; clockless_i = cl; crc_en_i = ce;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid_i = 1'b1; rx_byte_i = b;
    @(posedge clk); @(negedge clk);
    rx_valid_i = 1'b0; rx_byte_i = 8'hA5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // full response with configurable filler, marker and CRC corruption
  task automatic run_read(input string tag, input logic [7:0] op, input logic ce,
                          input int nfill, input logic [7:0] mark,
                          input logic [31:0] data, input logic bad_crc,
                          input logic [2:0] exp_code);
    logic [15:0] c;
    do_start(op, 1'b0, ce);
    send(op);
    send(8'h00);
    for (int i = 0; i < nfill; i++) send(8'h00);
    send(mark);
    for (int i = 3; i >= 0; i--) begin
      if (i == 0 && !ce) begin
        send(data[7:0]);
      end else begin
        send(data[i*8 +: 8]);
        chk({tag, " early done"}, {31'd0, done_o}, 32'd0);
      end
    end
    if (ce) begin
      c = ref_crc(data);
      if (bad_crc) c = c ^ 16'h0001;
      send(c[15:8]);
      chk({tag, " early done"}, {31'd0, done_o}, 32'd0);
      send(c[7:0]);
    end
    chk({tag, " done"}, {31'd0, done_o}, 32'd1);
    chk({tag, " code"}, {29'd0, err_o}, {29'd0, exp_code});
    chk({tag, " word"}, word_o, data);
    idle(1);
    chk({tag, " R9 pulse"}, {31'd0, done_o}, 32'd0);
    chk({tag, " R9 quiet"}, {29'd0, err_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset done", {31'd0, done_o}, 32'd0);
    chk("R1 reset err", {29'd0, err_o}, 32'd0);
    chk("R1 reset word", word_o, 32'd0);
  endtask

  task automatic t_echo_bad;
    do_start(8'hCA, 1'b0, 1'b0);
    send(8'hCB);
    chk("R2 echo done", {31'd0, done_o}, 32'd1);
    chk("R2 echo code", {29'd0, err_o}, 32'd1);
  endtask

  task automatic t_status_bad;
    do_start(8'hCA, 1'b0, 1'b0);
    send(8'hCA);
    chk("R3 early", {31'd0, done_o}, 32'd0);
    send(8'h05);
    chk("R3 status done", {31'd0, done_o}, 32'd1);
    chk("R3 status code", {29'd0, err_o}, 32'd2);
  endtask

  task automatic t_clockless;
    do_start(8'hC4, 1'b1, 1'b1);
    send(8'h00);
    send(8'h7F);
    chk("R4 no early stop", {31'd0, done_o}, 32'd0);
    send(8'h00);
    send(8'hF3);
    send(8'h9A); send(8'hBC); send(8'hDE);
    chk("R4 early", {31'd0, done_o}, 32'd0);
    send(8'hF0);
    chk("R4 done without crc", {31'd0, done_o}, 32'd1);
    chk("R4 code", {29'd0, err_o}, 32'd0);
    chk("R4 word", word_o, 32'h9ABCDEF0);
  endtask

  task automatic t_nostart;
    do_start(8'hCA, 1'b0, 1'b0);
    send(8'hCA); send(8'h00);
    for (int i = 0; i < 7; i++) send(8'h00);
    chk("R6 not yet", {31'd0, done_o}, 32'd0);
    send(8'hE3);
    chk("R6 done", {31'd0, done_o}, 32'd1);
    chk("R6 code", {29'd0, err_o}, 32'd3);
  endtask

  task automatic t_ignore;
    logic [31:0] held;
    held = word_o;
    send(8'hCA); send(8'h00); send(8'hF3); send(8'h11); send(8'h22);
    send(8'h33); send(8'h44);
    chk("R10 no done", {31'd0, done_o}, 32'd0);
    chk("R10 word held", word_o, held);
  endtask

  task automatic t_gaps;
    do_start(8'hCA, 1'b0, 1'b0);
    rx_byte_i = 8'h77; idle(2);
    send(8'hCA); idle(3);
    send(8'h00); send(8'hF3);
    send(8'h01); idle(1); send(8'h02); send(8'h03); idle(2);
    chk("R9 gap no done", {31'd0, done_o}, 32'd0);
    send(8'h04);
    chk("R9 gap done", {31'd0, done_o}, 32'd1);
    chk("R9 gap word", word_o, 32'h01020304);
  endtask

  task automatic t_restart;
    do_start(8'hCA, 1'b0, 1'b0);
    send(8'hCA); send(8'h00); send(8'h00);
    do_start(8'hC4, 1'b0, 1'b0);
    send(8'hC4); send(8'h00); send(8'hF3);
    send(8'hAA); send(8'hBB); send(8'hCC); send(8'hDD);
    chk("R1 restart done", {31'd0, done_o}, 32'd1);
    chk("R1 restart code", {29'd0, err_o}, 32'd0);
    chk("R1 restart word", word_o, 32'hAABBCCDD);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; opcode_i = 8'h00; clockless_i = 1'b0;
    crc_en_i = 1'b0; rx_valid_i = 1'b0; rx_byte_i = 8'h00;
    idle(3);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    t_reset;
    t_ignore;
    run_read("R7 plain", 8'hCA, 1'b0, 0, 8'hF3, 32'h11223344, 1'b0, 3'd0);
    run_read("R5 fillers", 8'hCA, 1'b0, 3, 8'hF3, 32'hDEADBEEF, 1'b0, 3'd0);
    run_read("R5 last slot", 8'hC4, 1'b0, 7, 8'hF0, 32'h00FF00FF, 1'b0, 3'd0);
    run_read("R8 crc good", 8'hCA, 1'b1, 1, 8'hF3, 32'h12345678, 1'b0, 3'd0);
    run_read("R8 crc good2", 8'hCA, 1'b1, 0, 8'hF3, 32'h00000000, 1'b0, 3'd0);
    run_read("R8 crc bad", 8'hCA, 1'b1, 2, 8'hF3, 32'hCAFEF00D, 1'b1, 3'd4);
    t_echo_bad;
    t_status_bad;
    t_clockless;
    t_nostart;
    t_ignore;
    t_gaps;
    t_restart;
    idle(2);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule